// File: doc/BRIEF.md
# Interleaved Sub-band Reorder Unit

This unit sits between a two-lane column wavelet processor and the temporal filtering stage. The column processor delivers its coefficients two at a time, and the pair type alternates. One valid cycle carries the high-band pair for a position: the HL coefficient on lane A and the HH coefficient on lane B. The next valid cycle carries the matching low-band pair: LL on lane A and LH on lane B. Then the pattern starts again.

The unit keeps the high-band pair in a holding register. When the matching low-band pair arrives, it presents all four sub-band coefficients of that position together on four dedicated ports, with a single output strobe. The unit does no arithmetic. It only captures, aligns and registers the coefficients.

A phase bit records which pair type the unit expects next. Cycles with the input strobe low leave this bit unchanged, so the source may insert idle gaps anywhere in the stream.

Top module: `subband_reorder`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 0 and all four coefficient outputs are 0.
- R2: The first valid input after reset is taken as the high-band pair: `in_a` is HL and `in_b` is HH.
- R3: The valid input that follows a high-band pair is taken as the low-band pair (`in_a` is LL, `in_b` is LH). On the clock edge that accepts it, `out_ll`, `out_lh`, `out_hl` and `out_hh` are loaded together, and `out_valid` is 1 for the following cycle.
- R4: `out_valid` is high for exactly one cycle per complete group. It is never high in two consecutive cycles.
- R5: A cycle with `in_valid` low does not change the expected pair type.
- R6: Accepting a high-band pair alone never raises `out_valid` in the next cycle.
- R7: While `out_valid` is low, the four coefficient outputs hold the values of the last completed group.
- R8: With `in_valid` held high, the unit completes one group every two cycles and drops no coefficient.
- R9: Lane values presented while `in_valid` is low change neither the held HL/HH values nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pair strobe |
| in_a | input | 15 | Lane A coefficient (HL or LL, by phase) |
| in_b | input | 15 | Lane B coefficient (HH or LH, by phase) |
| out_valid | output | 1 | One-cycle strobe for a complete group |
| out_ll | output | 15 | LL coefficient of the group |
| out_lh | output | 15 | LH coefficient of the group |
| out_hl | output | 15 | HL coefficient of the group |
| out_hh | output | 15 | HH coefficient of the group |

## Verification
The assertions check, on every cycle:
- the strobe is never high twice in a row;
- idle cycles leave the phase unchanged;
- a high-band pair alone never produces a strobe;
- the outputs stay stable between strobes;
- the LL and LH outputs of each group come from the lanes in the accepting cycle.

Only the bench scenarios can show that the right HL and HH values travel through the holding register and survive idle gaps filled with unrelated lane values. The same applies to the group count in a continuous stream, and to the lane-to-port assignment that R2 and R3 require.

// File: rtl/subband_reorder_pkg.sv
// Package: shared widths and phase encoding for the sub-band reorder unit.
// Assumes the phase encoding below is used by every module of the block.
package subband_reorder_pkg;

    // Default coefficient width carried on every lane and output.
    parameter int unsigned COEF_W_DEF = 15;

    // Pair type expected on the next valid input cycle.
    typedef enum logic {
        PH_HIGH_PAIR = 1'b0,   // lanes carry (HL, HH)
        PH_LOW_PAIR  = 1'b1    // lanes carry (LL, LH)
    } pair_phase_e;

endpackage

// File: rtl/reorder_phase_tracker.sv
// Module: keeps track of which pair type the next valid input carries.
// Assumes the source strictly alternates pair types on valid cycles and
// starts every stream with a high-band pair after reset.
module reorder_phase_tracker
    import subband_reorder_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output pair_phase_e phase,
    output logic        take_high,
    output logic        take_low
);

    pair_phase_e phase_q;

    // Toggle the phase only on accepted input cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH_PAIR;
        end else if (in_valid) begin
            phase_q <= (phase_q == PH_HIGH_PAIR) ? PH_LOW_PAIR : PH_HIGH_PAIR;
        end
    end

    // Decode the per-cycle capture enables from phase and strobe.
    always_comb begin
        take_high = in_valid && (phase_q == PH_HIGH_PAIR);
        take_low  = in_valid && (phase_q == PH_LOW_PAIR);
    end

    assign phase = phase_q;

endmodule

// File: rtl/reorder_pair_hold.sv
// Module: holds the high-band (HL, HH) pair until its low-band partner comes.
// Assumes take_high is asserted only on a valid high-band cycle.
module reorder_pair_hold #(
    parameter int unsigned COEF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_high,
    input  logic [COEF_W-1:0] lane_a,
    input  logic [COEF_W-1:0] lane_b,
    output logic [COEF_W-1:0] held_hl,
    output logic [COEF_W-1:0] held_hh
);

    // Capture lane A as HL and lane B as HH on a high-band cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hl <= '0;
            held_hh <= '0;
        end else if (take_high) begin
            held_hl <= lane_a;
            held_hh <= lane_b;
        end
    end

endmodule

// File: rtl/reorder_out_stage.sv
// Module: registers one complete four-coefficient group and its strobe.
// Assumes take_low marks the cycle whose lanes carry (LL, LH) and that the
// held HL/HH inputs belong to the same position.
module reorder_out_stage #(
    parameter int unsigned COEF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_low,
    input  logic [COEF_W-1:0] lane_a,
    input  logic [COEF_W-1:0] lane_b,
    input  logic [COEF_W-1:0] held_hl,
    input  logic [COEF_W-1:0] held_hh,
    output logic              grp_valid,
    output logic [COEF_W-1:0] grp_ll,
    output logic [COEF_W-1:0] grp_lh,
    output logic [COEF_W-1:0] grp_hl,
    output logic [COEF_W-1:0] grp_hh
);

    // The strobe follows the low-band capture by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_valid <= 1'b0;
        end else begin
            grp_valid <= take_low;
        end
    end

    // Load all four coefficients together; hold them between groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_ll <= '0;
            grp_lh <= '0;
            grp_hl <= '0;
            grp_hh <= '0;
        end else if (take_low) begin
            grp_ll <= lane_a;
            grp_lh <= lane_b;
            grp_hl <= held_hl;
            grp_hh <= held_hh;
        end
    end

endmodule

// File: rtl/subband_reorder.sv
// Module: top of the reorder unit. It turns the alternating (HL,HH)/(LL,LH)
// pair stream into four parallel sub-band outputs with one strobe.
// Assumes a synchronous active-low reset and a source that never breaks the
// alternation. The first valid cycle after reset is a high-band pair.
module subband_reorder
    import subband_reorder_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [COEF_W-1:0] in_a,
    input  logic [COEF_W-1:0] in_b,
    output logic              out_valid,
    output logic [COEF_W-1:0] out_ll,
    output logic [COEF_W-1:0] out_lh,
    output logic [COEF_W-1:0] out_hl,
    output logic [COEF_W-1:0] out_hh
);

    pair_phase_e       phase;
    logic              take_high;
    logic              take_low;
    logic [COEF_W-1:0] held_hl;
    logic [COEF_W-1:0] held_hh;

    reorder_phase_tracker u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .phase     (phase),
        .take_high (take_high),
        .take_low  (take_low)
    );

    reorder_pair_hold #(.COEF_W(COEF_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_high (take_high),
        .lane_a    (in_a),
        .lane_b    (in_b),
        .held_hl   (held_hl),
        .held_hh   (held_hh)
    );

    reorder_out_stage #(.COEF_W(COEF_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_low  (take_low),
        .lane_a    (in_a),
        .lane_b    (in_b),
        .held_hl   (held_hl),
        .held_hh   (held_hh),
        .grp_valid (out_valid),
        .grp_ll    (out_ll),
        .grp_lh    (out_lh),
        .grp_hl    (out_hl),
        .grp_hh    (out_hh)
    );

endmodule

// File: rtl/subband_reorder_chk.sv
// Module: assertion checker for the reorder unit, bound to the top.
// Assumes it sees the top's ports and the internal phase signal.
module subband_reorder_chk #(
    parameter int unsigned COEF_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [COEF_W-1:0] in_a,
    input logic [COEF_W-1:0] in_b,
    input logic              out_valid,
    input logic [COEF_W-1:0] out_ll,
    input logic [COEF_W-1:0] out_lh,
    input logic [COEF_W-1:0] out_hl,
    input logic [COEF_W-1:0] out_hh,
    input logic              phase_bit
);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    idle_keeps_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase_bit));

    // R6
    high_pair_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !phase_bit) |=> !out_valid);

    // R7
    hold_between_groups_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_ll) && $stable(out_lh) && $stable(out_hl) && $stable(out_hh)));

    // R3
    low_pair_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase_bit) |=> (out_valid && out_ll == $past(in_a) && out_lh == $past(in_b)));

endmodule

bind subband_reorder subband_reorder_chk #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ll    (out_ll),
    .out_lh    (out_lh),
    .out_hl    (out_hl),
    .out_hh    (out_hh),
    .phase_bit (phase)
);

// File: tb/sim_subband_reorder.sv
// Bench: directed scenarios for the sub-band reorder unit, one task each.
module sim_subband_reorder;

    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_ll, out_lh, out_hl, out_hh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 250 MHz clock
    always #2 clk = ~clk;

    subband_reorder #(.COEF_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ll(out_ll), .out_lh(out_lh),
        .out_hl(out_hl), .out_hh(out_hh)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle on the lanes, then sample 1 ns after the edge.
    task automatic step(input logic v, input int a, input int b);
        @(negedge clk);
        in_valid = v;
        in_a = W'(a);
        in_b = W'(b);
        @(posedge clk);
        #1;
    endtask

    task automatic check_group(input string req, input int ll, input int lh, input int hl, input int hh);
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " ll"}, int'(out_ll), ll);
        check({req, " lh"}, int'(out_lh), lh);
        check({req, " hl"}, int'(out_hl), hl);
        check({req, " hh"}, int'(out_hh), hh);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b1, 77, 88);
        step(1'b0, 0, 0);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 ll in reset", int'(out_ll), 0);
        rst_n = 1'b1;
        step(1'b0, 0, 0);
        check("R1 valid after release", int'(out_valid), 0);
        check("R1 hh after release", int'(out_hh), 0);
    endtask

    task automatic t_basic();
        step(1'b1, 101, 202);
        check("R6 no strobe after high pair", int'(out_valid), 0);
        step(1'b1, 303, 404);
        check_group("R2 R3 first group", 303, 404, 101, 202);
        step(1'b0, 999, 888);
        check("R4 strobe drops", int'(out_valid), 0);
        check("R7 ll held", int'(out_ll), 303);
        check("R7 hh held", int'(out_hh), 202);
    endtask

    task automatic t_gaps();
        step(1'b1, 11, 22);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 5000 + i, 6000 + i);
            check("R9 no strobe in gap", int'(out_valid), 0);
        end
        check("R9 outputs untouched", int'(out_hl), 101);
        step(1'b1, 33, 44);
        check_group("R5 R9 group after gap", 33, 44, 11, 22);
        step(1'b0, 1, 2);
        step(1'b0, 3, 4);
        step(1'b1, 55, 66);
        check("R5 gap before high pair", int'(out_valid), 0);
        step(1'b1, 77, 32767);
        check_group("R5 phase kept", 77, 32767, 55, 66);
    endtask

    task automatic t_stream();
        int strobes = 0;
        for (int g = 0; g < 6; g++) begin
            step(1'b1, 1000 + g, 2000 + g);
            if (out_valid) strobes++;
            step(1'b1, 3000 + g, 4000 + g);
            if (out_valid) strobes++;
            check_group("R8 stream group", 3000 + g, 4000 + g, 1000 + g, 2000 + g);
        end
        check("R8 R4 strobe count", strobes, 6);
        step(1'b0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_stream();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule